// File: doc/BRIEF.md
# Read Leveling Phase Sweep Detector

The block calibrates the read strobe delay of every byte lane of a DRAM interface. After a start request it drives one shared delay setting to all lanes and walks it through each step of a full phase. At each step it asks an external command issuer for a single read, with a request held until acknowledged, while the DRAM sits in its fixed pattern-output mode. It then inspects the burst of captured bytes on each lane. All bits of a lane share the lane's delay.

A lane passes a step when its burst is a clean alternation of all-ones and all-zeros bytes. The pass/fail bit of each step is stored in a per-lane result vector. While the sweep runs, the block tracks the longest unbroken run of passing steps on each lane. After the final step it raises a done flag and reports the centre of that run as the lane's recommended delay. A lane that never passed gets an error flag instead. Lanes are judged independently but swept together. The delay lines, the mode register writes and the command encoding live outside the block. The only command it ever asks for is a read.

Top module: `rdlvl_sweep`

## Requirements
- R1: After reset `rd_req_o`, `done_o` and `busy_o` are 0, and every `delay_o` field, every `result_o` bit and every `center_o` field is 0.
- R2: A cycle with `start_i` high clears all result bits, sets the step to 0 and makes `rd_req_o` high in the next cycle. This happens from any state, including in the middle of a request or a burst, and after done.
- R3: `rd_req_o` stays high until a cycle with `rd_ack_i` high and is never high while `done_o` is high. Each lane's `delay_o` field (STEP_W bits, lane l at bits l*STEP_W) equals the current step index and does not change while a request is pending.
- R4: After an acknowledge the block collects BURST_LEN bytes per lane, one on each cycle with `cap_valid_i` high. Lane l's byte is `cap_data_i[l*LANE_W +: LANE_W]`. A lane passes when its first byte is all-ones or all-zeros and each later byte is the bitwise inverse of the one before. `cap_valid_i` outside a burst, including in the acknowledge cycle, is ignored.
- R5: At the end of the burst, bit `l*NUM_STEPS + step` of `result_o` becomes 1 exactly when lane l passed. Bits of steps not yet completed stay 0, and no bit clears except on start.
- R6: After the burst of step NUM_STEPS-1, `done_o` rises, `busy_o` falls and no further read is requested. Otherwise the step increments by one and a new request follows in the next cycle. `busy_o` is high while requesting or collecting.
- R7: `center_o` for lane l equals s + (n-1)/2 (integer division), where s is the first step and n the length of the longest run of consecutive passing steps. On equal lengths the earliest run wins, and runs do not wrap from the last step to step 0. The value tracks the results recorded so far and is final when `done_o` is high.
- R8: `err_o[l]` is 1 and `center_o` for lane l is 0 while lane l has no passing step.
- R9: The lanes are evaluated independently: one lane's bytes never affect another lane's result bits, centre or error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart the sweep |
| rd_req_o | output | 1 | Request one training read |
| rd_ack_i | input | 1 | Command issuer accepted the read |
| cap_valid_i | input | 1 | Captured byte beat valid |
| cap_data_i | input | NUM_LANES*LANE_W | Captured byte per lane |
| delay_o | output | NUM_LANES*STEP_W | Strobe delay setting per lane |
| result_o | output | NUM_LANES*NUM_STEPS | Pass bit per lane per step |
| done_o | output | 1 | Sweep complete |
| busy_o | output | 1 | Sweep in progress |
| center_o | output | NUM_LANES*STEP_W | Centre of longest passing run per lane |
| err_o | output | NUM_LANES | Lane has no passing step |

## Verification
The checker holds on every cycle the request handshake, the stability of the delay during a pending request, the rule that result bits only ever set and at most one per lane per cycle, the absence of requests after done, and, at completion, that an error lane has an empty result vector and a good lane's centre lands on a passing step. Pattern classification, the exact result bits, the longest-run centre with its earliest-wins tie rule and restarts mid-request or mid-burst can only be shown by the bench. There a behavioural model collects each burst in a queue and scans the stored results, and its output is compared with the design on every clock.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CAP  = 2'd2,
    ST_DONE = 2'd3
  } sweep_st_e;
endpackage

// File: rtl/rdlvl_ctrl.sv
module rdlvl_ctrl
  import rdlvl_pkg::*;
#(
  parameter int NUM_STEPS = 64,
  parameter int BURST_LEN = 8,
  localparam int STEP_W = $clog2(NUM_STEPS),
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_ack_i,
  input  logic              cap_valid_i,
  output logic              rd_req_o,
  output logic              beat_en_o,
  output logic              first_beat_o,
  output logic              rec_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  sweep_st_e         state_q;
  logic [STEP_W-1:0] step_q;
  logic [BEAT_W-1:0] beat_q;

  always_comb begin
    rd_req_o     = (state_q == ST_REQ);
    done_o       = (state_q == ST_DONE);
    busy_o       = (state_q == ST_REQ) || (state_q == ST_CAP);
    beat_en_o    = (state_q == ST_CAP) && cap_valid_i && !start_i;
    first_beat_o = (beat_q == '0);
    rec_o        = beat_en_o && (beat_q == LAST_BEAT);
    step_o       = step_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      beat_q  <= '0;
    end else if (start_i) begin
      state_q <= ST_REQ;
      step_q  <= '0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_REQ: if (rd_ack_i) begin
          state_q <= ST_CAP;
          beat_q  <= '0;
        end
        ST_CAP: if (beat_en_o) begin
          if (beat_q == LAST_BEAT) begin
            beat_q <= '0;
            if (step_q == LAST_STEP) state_q <= ST_DONE;
            else begin
              step_q  <= step_q + STEP_W'(1);
              state_q <= ST_REQ;
            end
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rdlvl_lane_chk.sv
module rdlvl_lane_chk #(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              beat_en_i,
  input  logic              first_i,
  input  logic [LANE_W-1:0] byte_i,
  output logic              pass_o
);
  logic              ok_q;
  logic [LANE_W-1:0] prev_q;
  logic              beat_ok, ok_eff;

  // first beat: any solid byte; later beats: inverse of the previous one
  always_comb begin
    beat_ok = first_i ? ((byte_i == '0) || (byte_i == '1)) : (byte_i == ~prev_q);
    ok_eff  = first_i ? 1'b1 : ok_q;
    pass_o  = ok_eff && beat_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= 1'b1;
      prev_q <= '0;
    end else if (clr_i) begin
      ok_q   <= 1'b1;
      prev_q <= '0;
    end else if (beat_en_i) begin
      ok_q   <= pass_o;
      prev_q <= byte_i;
    end
  end
endmodule

// File: rtl/rdlvl_run_track.sv
module rdlvl_run_track #(
  parameter int NUM_STEPS = 64,
  localparam int STEP_W = $clog2(NUM_STEPS),
  localparam int LEN_W  = STEP_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 rec_i,
  input  logic                 pass_i,
  input  logic [STEP_W-1:0]    step_i,
  output logic [NUM_STEPS-1:0] result_o,
  output logic [STEP_W-1:0]    center_o,
  output logic                 err_o
);
  logic [NUM_STEPS-1:0] res_q;
  logic [LEN_W-1:0]     cur_len_q, best_len_q, nxt_len;
  logic [STEP_W-1:0]    cur_start_q, best_start_q, nxt_start;
  logic [LEN_W-1:0]     half;

  always_comb begin
    nxt_len   = cur_len_q + LEN_W'(1);
    nxt_start = (cur_len_q == '0) ? step_i : cur_start_q;
    half      = (best_len_q - LEN_W'(1)) >> 1;
    err_o     = (best_len_q == '0);
    center_o  = err_o ? '0 : best_start_q + half[STEP_W-1:0];
    result_o  = res_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q        <= '0;
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (clr_i) begin
      res_q        <= '0;
      cur_len_q    <= '0;
      cur_start_q  <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
    end else if (rec_i) begin
      res_q[step_i] <= pass_i;
      if (pass_i) begin
        cur_len_q   <= nxt_len;
        cur_start_q <= nxt_start;
        // strict compare keeps the earliest of equally long runs
        if (nxt_len > best_len_q) begin
          best_len_q   <= nxt_len;
          best_start_q <= nxt_start;
        end
      end else begin
        cur_len_q <= '0;
      end
    end
  end
endmodule

// File: rtl/rdlvl_sweep.sv
module rdlvl_sweep #(
  parameter int NUM_LANES = 2,
  parameter int NUM_STEPS = 64,
  parameter int BURST_LEN = 8,
  parameter int LANE_W    = 8,
  localparam int STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  output logic                           rd_req_o,
  input  logic                           rd_ack_i,
  input  logic                           cap_valid_i,
  input  logic [NUM_LANES*LANE_W-1:0]    cap_data_i,
  output logic [NUM_LANES*STEP_W-1:0]    delay_o,
  output logic [NUM_LANES*NUM_STEPS-1:0] result_o,
  output logic                           done_o,
  output logic                           busy_o,
  output logic [NUM_LANES*STEP_W-1:0]    center_o,
  output logic [NUM_LANES-1:0]           err_o
);
  logic              beat_en, first_beat, rec;
  logic [STEP_W-1:0] step;

  rdlvl_ctrl #(
    .NUM_STEPS(NUM_STEPS),
    .BURST_LEN(BURST_LEN)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rd_ack_i    (rd_ack_i),
    .cap_valid_i (cap_valid_i),
    .rd_req_o    (rd_req_o),
    .beat_en_o   (beat_en),
    .first_beat_o(first_beat),
    .rec_o       (rec),
    .step_o      (step),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic lane_pass;

    assign delay_o[l*STEP_W +: STEP_W] = step;

    rdlvl_lane_chk #(.LANE_W(LANE_W)) pat_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (start_i),
      .beat_en_i(beat_en),
      .first_i  (first_beat),
      .byte_i   (cap_data_i[l*LANE_W +: LANE_W]),
      .pass_o   (lane_pass)
    );

    rdlvl_run_track #(.NUM_STEPS(NUM_STEPS)) run_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (start_i),
      .rec_i   (rec),
      .pass_i  (lane_pass),
      .step_i  (step),
      .result_o(result_o[l*NUM_STEPS +: NUM_STEPS]),
      .center_o(center_o[l*STEP_W +: STEP_W]),
      .err_o   (err_o[l])
    );
  end
endmodule

// File: rtl/rdlvl_sweep_chk.sv
module rdlvl_sweep_chk #(
  parameter int NUM_LANES = 2,
  parameter int NUM_STEPS = 64,
  parameter int BURST_LEN = 8,
  parameter int LANE_W    = 8,
  localparam int STEP_W   = $clog2(NUM_STEPS)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           start_i,
  input logic                           rd_req_o,
  input logic                           rd_ack_i,
  input logic                           cap_valid_i,
  input logic [NUM_LANES*LANE_W-1:0]    cap_data_i,
  input logic [NUM_LANES*STEP_W-1:0]    delay_o,
  input logic [NUM_LANES*NUM_STEPS-1:0] result_o,
  input logic                           done_o,
  input logic                           busy_o,
  input logic [NUM_LANES*STEP_W-1:0]    center_o,
  input logic [NUM_LANES-1:0]           err_o
);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> rd_req_o && (delay_o == '0) && (result_o == '0));

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o);

  a_r3_delay_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !start_i |=> $stable(delay_o));

  a_r3_no_req_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o && !busy_o);

  a_r5_bits_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((result_o & $past(result_o)) == $past(result_o)));

  a_r5_one_per_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($countones(result_o ^ $past(result_o)) <= NUM_LANES));

  a_r6_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_a
    a_r8_err_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && err_o[l] |-> (result_o[l*NUM_STEPS +: NUM_STEPS] == '0));

    a_r7_center_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !err_o[l] |->
        result_o[l*NUM_STEPS + int'(center_o[l*STEP_W +: STEP_W])]);
  end
endmodule

bind rdlvl_sweep rdlvl_sweep_chk #(
  .NUM_LANES(NUM_LANES),
  .NUM_STEPS(NUM_STEPS),
  .BURST_LEN(BURST_LEN),
  .LANE_W   (LANE_W)
) chk_i (.*);

// File: tb/rdlvl_sweep_tb.sv
`timescale 1ns/1ps
module rdlvl_sweep_tb_top;
  localparam int NL = 2;
  localparam int NS = 64;
  localparam int BL = 8;
  localparam int LW = 8;
  localparam int SW = 6;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            rd_ack_i = 1'b0;
  logic            cap_valid_i = 1'b0;
  logic [NL*LW-1:0] cap_data_i = '0;
  logic            rd_req_o, done_o, busy_o;
  logic [NL*SW-1:0] delay_o, center_o;
  logic [NL*NS-1:0] result_o;
  logic [NL-1:0]    err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  rdlvl_sweep #(.NUM_LANES(NL), .NUM_STEPS(NS), .BURST_LEN(BL), .LANE_W(LW)) dut_i (
    .clk_i, .rst_ni, .start_i, .rd_req_o, .rd_ack_i, .cap_valid_i, .cap_data_i,
    .delay_o, .result_o, .done_o, .busy_o, .center_o, .err_o
  );

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       m_mode = 0;   // 0 idle, 1 asking, 2 collecting, 3 finished
  int       m_step = 0;
  int       m_beats = 0;
  bit       m_res [NL][NS];
  logic [LW-1:0] m_q [NL][$];

  function automatic bit burst_ok(int l);
    if (!(m_q[l][0] == 8'h00 || m_q[l][0] == 8'hFF)) return 0;
    for (int i = 1; i < BL; i++)
      if (m_q[l][i] !== ~m_q[l][i-1]) return 0;
    return 1;
  endfunction

  function automatic void scan(int l, output int c, output bit e);
    int best = 0, bs = 0, cur = 0, cs = 0;
    for (int s = 0; s < NS; s++) begin
      if (m_res[l][s]) begin
        if (cur == 0) cs = s;
        cur++;
        if (cur > best) begin best = cur; bs = cs; end
      end else cur = 0;
    end
    e = (best == 0);
    c = e ? 0 : bs + (best - 1) / 2;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_mode = 0; m_step = 0; m_beats = 0;
      for (int l = 0; l < NL; l++) for (int s = 0; s < NS; s++) m_res[l][s] = 0;
    end else if (start_i) begin
      m_mode = 1; m_step = 0; m_beats = 0;
      for (int l = 0; l < NL; l++) for (int s = 0; s < NS; s++) m_res[l][s] = 0;
    end else if (m_mode == 1) begin
      if (rd_ack_i) begin
        m_mode = 2; m_beats = 0;
        for (int l = 0; l < NL; l++) m_q[l].delete();
      end
    end else if (m_mode == 2 && cap_valid_i) begin
      for (int l = 0; l < NL; l++) m_q[l].push_back(cap_data_i[l*LW +: LW]);
      m_beats++;
      if (m_beats == BL) begin
        for (int l = 0; l < NL; l++) m_res[l][m_step] = burst_ok(l);
        if (m_step == NS - 1) m_mode = 3;
        else begin m_step++; m_mode = 1; end
      end
    end
  end

  always @(negedge clk_i) begin
    logic [NL*NS-1:0] er;
    for (int l = 0; l < NL; l++) for (int s = 0; s < NS; s++) er[l*NS+s] = m_res[l][s];
    chk("R3", "rd_req_o", 256'(rd_req_o), 256'(m_mode == 1));
    chk("R6", "busy_o", 256'(busy_o), 256'(m_mode == 1 || m_mode == 2));
    chk("R6", "done_o", 256'(done_o), 256'(m_mode == 3));
    chk("R5", "result_o", 256'(result_o), 256'(er));
    for (int l = 0; l < NL; l++) begin
      int c; bit e;
      scan(l, c, e);
      chk("R3", "delay_o", 256'(delay_o[l*SW +: SW]), 256'(m_step));
      chk("R7", "center_o", 256'(center_o[l*SW +: SW]), 256'(c));
      chk("R8", "err_o", 256'(err_o[l]), 256'(e));
    end
  end

  // ---------------- stimulus ----------------
  function automatic bit lane_pass(int sc, int l, int s);
    case (sc)
      0: return (l == 0) ? (s >= 10 && s <= 20) : ((s >= 5 && s <= 7) || (s >= 30 && s <= 40));
      1: return (l == 0) ? 1'b0 : 1'b1;
      default: return (l == 0) ? ((s >= 2 && s <= 5) || (s >= 50 && s <= 53)) : (s == 63);
    endcase
  endfunction

  function automatic logic [LW-1:0] gen_byte(int sc, int l, int s, int b);
    logic [LW-1:0] base, v;
    base = ((s + l) % 2) ? 8'hFF : 8'h00;
    v = (b % 2) ? ~base : base;
    if (lane_pass(sc, l, s)) return v;
    case (s % 3)
      0: return (b == 4) ? ~base : v;                    // repeated byte
      1: return (b % 2) ? 8'hA5 : 8'h5A;                 // alternates, wrong start
      default: return (b == BL - 1) ? (v ^ 8'h01) : v;   // one flipped bit
    endcase
  endfunction

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic serve(int sc, int s);
    while (!rd_req_o) @(negedge clk_i);
    repeat (s % 3) @(negedge clk_i);
    rd_ack_i = 1'b1;
    if (s % 5 == 0) begin  // R4: beat in the acknowledge cycle is ignored
      cap_valid_i = 1'b1;
      cap_data_i = {NL{8'h3C}};
    end
    @(negedge clk_i);
    rd_ack_i = 1'b0;
    cap_valid_i = 1'b0;
    for (int b = 0; b < BL; b++) begin
      if (b == 3 && s % 4 == 0) begin
        cap_valid_i = 1'b0;
        @(negedge clk_i);
      end
      cap_valid_i = 1'b1;
      for (int l = 0; l < NL; l++) cap_data_i[l*LW +: LW] = gen_byte(sc, l, s, b);
      @(negedge clk_i);
    end
    cap_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "reset req/done/busy", 256'({rd_req_o, done_o, busy_o}), 256'(0));
    chk("R1", "reset result", 256'(result_o), 256'(0));
    chk("R1", "reset delay/center", 256'({delay_o, center_o}), 256'(0));
    rst_ni = 1'b1;
    // R4: stray beats while idle have no effect
    cap_valid_i = 1'b1; cap_data_i = '1;
    repeat (3) @(negedge clk_i);
    cap_valid_i = 1'b0;
    chk("R4", "idle stray beats", 256'(result_o), 256'(0));

    // scenario 0: two windows on lane 1, one on lane 0
    pulse_start();
    chk("R2", "req after start", 256'(rd_req_o), 256'(1));
    for (int s = 0; s < NS; s++) serve(0, s);
    wait_done();
    chk("R7", "sc0 lane0 centre", 256'(center_o[0 +: SW]), 256'(15));
    chk("R9", "sc0 lane1 centre", 256'(center_o[SW +: SW]), 256'(35));
    chk("R4", "sc0 lane1 step6 pass", 256'(result_o[NS + 6]), 256'(1));
    chk("R4", "sc0 lane1 step8 fail", 256'(result_o[NS + 8]), 256'(0));
    // R6: stray handshake after done is ignored
    rd_ack_i = 1'b1; cap_valid_i = 1'b1;
    repeat (4) @(negedge clk_i);
    rd_ack_i = 1'b0; cap_valid_i = 1'b0;
    chk("R6", "done stays, no req", 256'({done_o, rd_req_o}), 256'(2'b10));

    // scenario 1: restart from done, then restart while a request is pending
    pulse_start();
    chk("R2", "results cleared", 256'(result_o), 256'(0));
    for (int s = 0; s < 5; s++) serve(1, s);
    while (!rd_req_o) @(negedge clk_i);
    pulse_start();
    chk("R2", "delay back to 0", 256'(delay_o), 256'(0));
    for (int s = 0; s < NS; s++) serve(1, s);
    wait_done();
    chk("R8", "sc1 lane0 err", 256'({err_o[0], center_o[0 +: SW]}), 256'({1'b1, 6'd0}));
    chk("R7", "sc1 lane1 full centre", 256'(center_o[SW +: SW]), 256'(31));

    // scenario 2: restart in the middle of a burst, tie and last-step cases
    pulse_start();
    for (int s = 0; s < 3; s++) serve(2, s);
    while (!rd_req_o) @(negedge clk_i);
    rd_ack_i = 1'b1;
    @(negedge clk_i);
    rd_ack_i = 1'b0;
    for (int b = 0; b < 3; b++) begin
      cap_valid_i = 1'b1; cap_data_i = '1;
      @(negedge clk_i);
    end
    cap_valid_i = 1'b0;
    pulse_start();
    for (int s = 0; s < NS; s++) serve(2, s);
    wait_done();
    chk("R7", "sc2 lane0 tie earliest", 256'(center_o[0 +: SW]), 256'(3));
    chk("R7", "sc2 lane1 last step", 256'(center_o[SW +: SW]), 256'(63));
    chk("R5", "sc2 lane1 only bit63", 256'(result_o[NS +: NS]), 256'(64'h8000_0000_0000_0000));
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule